// File: doc/BRIEF.md
# RTC Interrupt Flag and Enable Unit

This unit keeps the interrupt state of a real-time clock. It has a control register with three interrupt enables and a square-wave enable. It also has a status register with three cause flags and a summary bit. Single-cycle event pulses come in from the periodic divider, the alarm comparator and the calendar update engine. Each pulse sets its flag whether or not that source is enabled.

The interrupt pin is active-low and open-drain. It is modelled as a pull-low request, `irq_pull_o`. The request is high while any flag is set together with its enable. A processor reads the status register to learn the cause, and that read clears every flag. An event that arrives in the same cycle as the clearing read is kept for the next read. The active-low reset clears all enables and flags and releases the interrupt pin.

Register access uses a one-bit address: 0 selects control and 1 selects status. Read data is combinational and is zero when `rd_i` is low. Writes take effect at the clock edge.

Top module: `rtc_irq_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, all enables and flags are zero. `irq_pull_o` and `sqw_en_o` are 0, and reads of both registers return 0x00.
- R2: A write to control (address 0) stores the periodic enable at bit 6, the alarm enable at bit 5, the update enable at bit 4 and the square-wave enable at bit 3, at the clock edge. A read of control returns those bits, with bits 7 and 2:0 reading 0. `sqw_en_o` follows bit 3.
- R3: A pulse on `per_evt_i`, `alm_evt_i` or `upd_evt_i` sets status bit 6, 5 or 4 respectively at the next edge, whatever the enables are.
- R4: Status bit 7 reads as the OR, over the three sources, of the flag AND its enable. Status bits 3:0 read 0.
- R5: `irq_pull_o` is 1 exactly when some flag and its matching enable are both set.
- R6: A status read (address 1, `rd_i` high) returns the flags held before the edge and clears them at that edge. The request then drops in the next cycle.
- R7: An event pulse in the same cycle as a status read leaves its flag set after the read.
- R8: Writes to status change no flag.
- R9: A control read leaves the flags unchanged.
- R10: Clearing an enable masks the request but keeps the flag, so the flag can still be read.
- R11: `rdata_o` is 0x00 whenever `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | 0 = control, 1 = status |
| wdata_i | input | 8 | Write data |
| per_evt_i | input | 1 | Periodic event pulse |
| alm_evt_i | input | 1 | Alarm event pulse |
| upd_evt_i | input | 1 | Update-ended event pulse |
| rdata_o | output | 8 | Read data |
| irq_pull_o | output | 1 | 1 = drive the interrupt pin low |
| sqw_en_o | output | 1 | Square-wave enable |

## Verification
A wrong internal state shows at the ports as soon as it exists. The request and the control bits are combinational from the registers, so a flag that fails to set or clear changes `irq_pull_o` one cycle after the event or the read. A status read shows the flag value in the same cycle. The hardest cases are flags masked by their enables, because these move no pin. The bench therefore reads the status register back to see them. It also places events exactly on the clearing read, so a lost pulse shows up on the following read.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NSRC    = 3;  // 0 update, 1 alarm, 2 periodic
  localparam int unsigned SRC_LSB = 4;
  localparam int unsigned SQW_BIT = 3;
  localparam int unsigned SUM_BIT = 7;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/rtc_irq_ctrl_reg.sv
module rtc_irq_ctrl_reg #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [NSRC-1:0] en_d_i,
  input  logic            sqw_d_i,
  output logic [NSRC-1:0] en_o,
  output logic            sqw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      sqw_o <= 1'b0;
    end else if (we_i) begin
      en_o  <= en_d_i;
      sqw_o <= sqw_d_i;
    end
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_i,
  output logic [NSRC-1:0] flag_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[g] <= 1'b0;
      else if (evt_i[g])  flag_o[g] <= 1'b1;  // set beats read-clear
      else if (clr_i)     flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              per_evt_i,
  input  logic              alm_evt_i,
  input  logic              upd_evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_pull_o,
  output logic              sqw_en_o
);
  logic [NSRC-1:0] en_q, flag_q, evt_v, pend;
  logic            ctrl_we, stat_rd, sum;

  assign evt_v   = {per_evt_i, alm_evt_i, upd_evt_i};
  assign ctrl_we = wr_i && (addr_i == ADDR_CTRL);
  assign stat_rd = rd_i && (addr_i == ADDR_STAT);

  rtc_irq_ctrl_reg #(.NSRC(NSRC)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .en_d_i  (wdata_i[SRC_LSB +: NSRC]),
    .sqw_d_i (wdata_i[SQW_BIT]),
    .en_o    (en_q),
    .sqw_o   (sqw_en_o)
  );

  rtc_irq_flags #(.NSRC(NSRC)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_v),
    .clr_i  (stat_rd),
    .flag_o (flag_q)
  );

  assign pend       = flag_q & en_q;
  assign sum        = |pend;
  assign irq_pull_o = sum;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == ADDR_STAT) begin
        rdata_o[SRC_LSB +: NSRC] = flag_q;
        rdata_o[SUM_BIT]         = sum;
      end else begin
        rdata_o[SRC_LSB +: NSRC] = en_q;
        rdata_o[SQW_BIT]         = sqw_en_o;
      end
    end
  end
endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk
  import rtc_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic              addr_i,
  input logic [NSRC-1:0]   wen_i,
  input logic [NSRC-1:0]   evt_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_pull_o,
  input logic [NSRC-1:0]   flag_q,
  input logic [NSRC-1:0]   en_q
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) p_reset_quiet_r1: assert (!irq_pull_o && flag_q == '0);
  end

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CTRL) |=> en_q == $past(wen_i));

  p_evt_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  p_low_nibble_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_STAT) |-> rdata_o[3:0] == 4'h0);

  p_sum_is_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_STAT) |-> rdata_o[SUM_BIT] == irq_pull_o);

  p_read_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_STAT && evt_i == '0) |=> flag_q == '0);

  p_stat_write_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && addr_i == ADDR_STAT && evt_i == '0) |=> $stable(flag_q));
endmodule

bind rtc_irq_unit rtc_irq_unit_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .addr_i     (addr_i),
  .wen_i      (wdata_i[6:4]),
  .evt_i      (evt_v),
  .rdata_o    (rdata_o),
  .irq_pull_o (irq_pull_o),
  .flag_q     (flag_q),
  .en_q       (en_q)
);

// File: tb/test_rtc_irq_unit.sv
module test_rtc_irq_unit;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic per_evt_i = 1'b0, alm_evt_i = 1'b0, upd_evt_i = 1'b0;
  logic [7:0] rdata_o;
  logic irq_pull_o, sqw_en_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  rtc_irq_unit i_rtc_irq_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .per_evt_i(per_evt_i), .alm_evt_i(alm_evt_i),
    .upd_evt_i(upd_evt_i), .rdata_o(rdata_o), .irq_pull_o(irq_pull_o),
    .sqw_en_o(sqw_en_o)
  );

  // {wr, rd, addr, wdata[8], evt{per,alm,upd}[3], exp_rdata[8], exp_irq}
  localparam int NV = 19;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,8'h00,3'b000,8'h00,1'b0}, // R1 ctrl
    {1'b0,1'b1,1'b1,8'h00,3'b000,8'h00,1'b0}, // R1 status
    {1'b1,1'b0,1'b0,8'hFF,3'b000,8'h00,1'b0}, // R11 write all
    {1'b0,1'b1,1'b0,8'h00,3'b000,8'h78,1'b0}, // R2 readback
    {1'b0,1'b0,1'b0,8'h00,3'b100,8'h00,1'b0}, // R3 periodic
    {1'b0,1'b1,1'b0,8'h00,3'b000,8'h78,1'b1}, // R5 R9
    {1'b0,1'b1,1'b1,8'h00,3'b000,8'hC0,1'b1}, // R4 R6
    {1'b0,1'b1,1'b1,8'h00,3'b000,8'h00,1'b0}, // R6 cleared
    {1'b1,1'b0,1'b0,8'h00,3'b010,8'h00,1'b0}, // R3 alarm, disable
    {1'b0,1'b1,1'b0,8'h00,3'b000,8'h00,1'b0}, // R10 masked
    {1'b1,1'b0,1'b1,8'h00,3'b000,8'h00,1'b0}, // R8 status write
    {1'b1,1'b0,1'b0,8'h20,3'b000,8'h00,1'b0}, // alarm enable
    {1'b0,1'b1,1'b1,8'h00,3'b001,8'hA0,1'b1}, // R7 event on read
    {1'b0,1'b1,1'b1,8'h00,3'b000,8'h10,1'b0}, // R7 R4 kept, masked
    {1'b0,1'b1,1'b1,8'h00,3'b000,8'h00,1'b0}, // R6
    {1'b1,1'b0,1'b0,8'h10,3'b111,8'h00,1'b0}, // R3 all
    {1'b0,1'b1,1'b0,8'h00,3'b000,8'h10,1'b1}, // R5 update
    {1'b0,1'b1,1'b1,8'h00,3'b000,8'hF0,1'b1}, // R4 all flags
    {1'b0,1'b0,1'b0,8'h00,3'b000,8'h00,1'b0}  // R6 R11
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic r, input logic a, input logic [7:0] d,
                       input logic [2:0] e);
    wr_i = w; rd_i = r; addr_i = a; wdata_i = d;
    {per_evt_i, alm_evt_i, upd_evt_i} = e;
  endtask

  task automatic step_idle();
    drive(1'b0, 1'b0, 1'b0, 8'h00, 3'b000);
    @(posedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 irq in reset", {7'd0, irq_pull_o}, 8'h00);
    chk("R1 sqw in reset", {7'd0, sqw_en_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:12], VEC[i][11:9]);
      #1;
      chk($sformatf("R2-vec%0d rdata", i), rdata_o, VEC[i][8:1]);
      chk($sformatf("R5 vec%0d irq", i), {7'd0, irq_pull_o}, {7'd0, VEC[i][0]});
      @(posedge clk_i); @(negedge clk_i);
    end
    // R2 square-wave enable output
    drive(1'b1, 1'b0, 1'b0, 8'h08, 3'b000);
    @(posedge clk_i); @(negedge clk_i);
    chk("R2 sqw_en set", {7'd0, sqw_en_o}, 8'h01);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 3'b000);
    @(posedge clk_i); @(negedge clk_i);
    chk("R2 sqw_en clear", {7'd0, sqw_en_o}, 8'h00);
    // R1 reset mid-operation
    drive(1'b1, 1'b0, 1'b0, 8'h78, 3'b111);
    @(posedge clk_i); @(negedge clk_i);
    step_idle();
    chk("R5 before reset", {7'd0, irq_pull_o}, 8'h01);
    rst_ni = 1'b0;
    #1;
    chk("R1 irq async", {7'd0, irq_pull_o}, 8'h00);
    chk("R1 sqw async", {7'd0, sqw_en_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    drive(1'b0, 1'b1, 1'b0, 8'h00, 3'b000); #1;
    chk("R1 ctrl after reset", rdata_o, 8'h00);
    drive(1'b0, 1'b1, 1'b1, 8'h00, 3'b000); #1;
    chk("R1 status after reset", rdata_o, 8'h00);
    step_idle();
    // R8 write to status with data cannot set flags
    drive(1'b1, 1'b0, 1'b1, 8'hF0, 3'b000);
    @(posedge clk_i); @(negedge clk_i);
    drive(1'b0, 1'b1, 1'b1, 8'h00, 3'b000); #1;
    chk("R8 status after write", rdata_o, 8'h00);
    step_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule